// File: doc/BRIEF.md
# Crossing-Rotating Event Distributor

This block gathers the data of one bunch crossing from several upstream streams and hands the whole crossing to a single downstream processing node. Each source sends one frame per crossing: a run of data words whose final word carries a last marker. Each source has its own small buffer. Only when every source has closed its frame does the block treat the crossing as complete. It then sends that crossing, source by source, as one framed burst on the output link of the node whose turn it is. The nodes take turns in a fixed rotation, so with a rotation length of P each node receives one crossing in every P.

Sources need not be aligned with each other. One may finish early while another is still sending, and the crossing is only assembled at the output. A frame longer than a source buffer is cut short, and the burst is flagged as truncated so the node can discard or handle it.

The control is a three-state machine. `S_COLLECT` waits for all sources to finish and moves to `S_DRAIN` once every buffer holds a closed frame. `S_DRAIN` emits one stored word per cycle, moving to the next source when a source's last word goes out. After the last word of the highest source it moves to `S_ROTATE`. `S_ROTATE` lasts one cycle: it empties the buffers, advances the node pointer and returns to `S_COLLECT`.

Top module: `tmx_distributor`

## Requirements
- R1: After reset, no output link is valid, and the first completed crossing is sent on node 0.
- R2: No output link carries a word until every source has delivered a word with its last marker for the current crossing.
- R3: A burst carries every kept word of source 0 in arrival order, then those of source 1, and so on, one word per cycle with no gaps. No word is added or lost.
- R4: In a burst, `out_sop` is high only on its first word and `out_eop` is high only on its final word, which is the last word of the highest-numbered source. The last markers of lower sources do not show on the link.
- R5: The k-th completed crossing after reset goes to node k mod PERIOD. The pointer wraps from PERIOD-1 to 0.
- R6: At most one bit of `out_valid` is high in any cycle.
- R7: A word offered by a source after its own last word is ignored until the burst has been sent and the buffers are emptied.
- R8: A source frame longer than BUF_DEPTH keeps its first BUF_DEPTH-1 words plus its last word and drops the rest. Every word of that crossing's burst then has `out_trunc` high. Crossings with no over-long frame have `out_trunc` low, including the crossing after a truncated one.
- R9: PERIOD must lie in 15..34 or elaboration stops with an error. The default is 24, giving 24 output links.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | NUM_SRC | Per-source word strobe |
| in_last | input | NUM_SRC | Per-source last-word marker of the crossing frame |
| in_data | input | NUM_SRC*DATA_W | Per-source data, source s in bits [s*DATA_W +: DATA_W] |
| out_valid | output | PERIOD | Per-node word strobe |
| out_sop | output | PERIOD | Per-node first word of a burst |
| out_eop | output | PERIOD | Per-node final word of a burst |
| out_trunc | output | PERIOD | Per-node flag: burst lost words to buffer overflow |
| out_data | output | PERIOD*DATA_W | Per-node data, node n in bits [n*DATA_W +: DATA_W] |

## Verification
The assertions assume that each source closes every frame with a last marker, so a crossing always completes, and that a new frame starts only after the previous burst has left and the buffers are emptied. The stimulus meets this by waiting for the final word of each burst, plus two idle cycles, before it starts the next crossing. Within one crossing, source pacing is random and independent. Sources that have finished keep offering junk words, some of them with the last marker set, to exercise R7. Frame lengths are random, with directed cases at exactly BUF_DEPTH and just beyond it.

// File: rtl/tmx_pkg.sv
package tmx_pkg;
    typedef enum logic [1:0] {
        S_COLLECT = 2'd0,
        S_DRAIN   = 2'd1,
        S_ROTATE  = 2'd2
    } tmx_state_t;
endpackage

// File: rtl/tmx_src_buf.sv
// Holds one crossing frame from one source; the final slot is kept for the last word.
module tmx_src_buf #(
    parameter int DATA_W    = 16,
    parameter int BUF_DEPTH = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_valid,
    input  logic                          wr_last,
    input  logic [DATA_W-1:0]             wr_data,
    input  logic                          clear,
    input  logic [$clog2(BUF_DEPTH)-1:0]  rd_idx,
    output logic [DATA_W-1:0]             rd_data,
    output logic                          rd_last,
    output logic                          done,
    output logic                          trunc
);
    localparam int WP_W = $clog2(BUF_DEPTH + 1);
    localparam int RD_W = $clog2(BUF_DEPTH);

    logic [DATA_W:0]   mem [BUF_DEPTH];
    logic [WP_W-1:0]   wp;
    logic              room;
    logic              take;
    logic              drop;

    assign room = wp < WP_W'(BUF_DEPTH - 1);
    assign take = wr_valid && !done && (wr_last || room);
    assign drop = wr_valid && !done && !wr_last && !room;

    always_ff @(posedge clk) begin
        if (take) begin
            mem[wp[RD_W-1:0]] <= {wr_last, wr_data};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wp    <= '0;
            done  <= 1'b0;
            trunc <= 1'b0;
        end else begin
            if (take) begin
                wp <= wp + 1'b1;
                if (wr_last) begin
                    done <= 1'b1;
                end
            end
            if (drop) begin
                trunc <= 1'b1;
            end
        end
    end

    assign rd_data = mem[rd_idx][DATA_W-1:0];
    assign rd_last = mem[rd_idx][DATA_W];

    // R8: fill level never exceeds the buffer
    a_r8_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
        wp <= WP_W'(BUF_DEPTH));
    // R7: a closed frame stays closed and unchanged until cleared
    a_r7_frame_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !clear) |=> (done && $stable(wp)));
endmodule

// File: rtl/tmx_rr_node.sv
// Modulo-PERIOD destination pointer.
module tmx_rr_node #(
    parameter int PERIOD = 24
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      advance,
    output logic [$clog2(PERIOD)-1:0] node
);
    localparam int NODE_W = $clog2(PERIOD);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            node <= '0;
        end else if (advance) begin
            node <= (node == NODE_W'(PERIOD - 1)) ? '0 : node + 1'b1;
        end
    end

    // R5: wrap from the highest node back to node 0
    a_r5_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && node == NODE_W'(PERIOD - 1)) |=> node == '0);
    // R5: pointer stays in range
    a_r5_range: assert property (@(posedge clk) disable iff (!rst_n)
        node <= NODE_W'(PERIOD - 1));
endmodule

// File: rtl/tmx_distributor.sv
module tmx_distributor
    import tmx_pkg::*;
#(
    parameter int NUM_SRC   = 3,
    parameter int DATA_W    = 16,
    parameter int BUF_DEPTH = 8,
    parameter int PERIOD    = 24
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_SRC-1:0]          in_valid,
    input  logic [NUM_SRC-1:0]          in_last,
    input  logic [NUM_SRC*DATA_W-1:0]   in_data,
    output logic [PERIOD-1:0]           out_valid,
    output logic [PERIOD-1:0]           out_sop,
    output logic [PERIOD-1:0]           out_eop,
    output logic [PERIOD-1:0]           out_trunc,
    output logic [PERIOD*DATA_W-1:0]    out_data
);
    localparam int NODE_W = $clog2(PERIOD);
    localparam int SRC_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
    localparam int RD_W   = $clog2(BUF_DEPTH);

    if (PERIOD < 15 || PERIOD > 34) begin : g_period_check
        $error("tmx_distributor: PERIOD must be within 15..34");
    end

    tmx_state_t          state, state_nx;
    logic [NODE_W-1:0]   node;
    logic [SRC_W-1:0]    src_sel;
    logic [RD_W-1:0]     rd_idx;
    logic                first_word;

    logic [DATA_W-1:0]   buf_data [NUM_SRC];
    logic [NUM_SRC-1:0]  buf_last;
    logic [NUM_SRC-1:0]  buf_done;
    logic [NUM_SRC-1:0]  buf_trunc;

    logic                all_done;
    logic                any_trunc;
    logic                cur_last;
    logic                final_word;
    logic                rotating;

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        tmx_src_buf #(.DATA_W(DATA_W), .BUF_DEPTH(BUF_DEPTH)) u_buf (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_valid (in_valid[s]),
            .wr_last  (in_last[s]),
            .wr_data  (in_data[s*DATA_W +: DATA_W]),
            .clear    (rotating),
            .rd_idx   (rd_idx),
            .rd_data  (buf_data[s]),
            .rd_last  (buf_last[s]),
            .done     (buf_done[s]),
            .trunc    (buf_trunc[s])
        );
    end

    tmx_rr_node #(.PERIOD(PERIOD)) u_rr (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (rotating),
        .node    (node)
    );

    assign all_done   = &buf_done;
    assign any_trunc  = |buf_trunc;
    assign cur_last   = buf_last[src_sel];
    assign final_word = cur_last && (src_sel == SRC_W'(NUM_SRC - 1));
    assign rotating   = (state == S_ROTATE);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_COLLECT;
        end else begin
            state <= state_nx;
        end
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            S_COLLECT: if (all_done)   state_nx = S_DRAIN;
            S_DRAIN:   if (final_word) state_nx = S_ROTATE;
            S_ROTATE:                  state_nx = S_COLLECT;
            default:                   state_nx = S_COLLECT;
        endcase
    end

    // Read sequencing through the buffers
    always_ff @(posedge clk) begin
        if (!rst_n || state != S_DRAIN) begin
            src_sel    <= '0;
            rd_idx     <= '0;
            first_word <= 1'b1;
        end else begin
            first_word <= 1'b0;
            if (cur_last) begin
                src_sel <= src_sel + 1'b1;
                rd_idx  <= '0;
            end else begin
                rd_idx  <= rd_idx + 1'b1;
            end
        end
    end

    // Outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= '0;
            out_sop   <= '0;
            out_eop   <= '0;
            out_trunc <= '0;
            out_data  <= '0;
        end else begin
            out_valid <= '0;
            out_sop   <= '0;
            out_eop   <= '0;
            out_trunc <= '0;
            if (state == S_DRAIN) begin
                out_valid[node]                   <= 1'b1;
                out_sop[node]                     <= first_word;
                out_eop[node]                     <= final_word;
                out_trunc[node]                   <= any_trunc;
                out_data[node*DATA_W +: DATA_W]   <= buf_data[src_sel];
            end
        end
    end

    // R6: one link at a time
    a_r6_single_link: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(out_valid));
    // R2: nothing leaves while a source frame is still open
    a_r2_hold_until_complete: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_COLLECT && !all_done) |=> out_valid == '0);
    // R5: node pointer moves only between bursts
    a_r5_node_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_ROTATE) |=> $stable(node));
    // R4: framing bits only ride on valid words
    a_r4_frame_on_valid: assert property (@(posedge clk) disable iff (!rst_n)
        ((out_sop | out_eop) & ~out_valid) == '0);
endmodule

// File: tb/test_tmx_distributor.sv
module test_tmx_distributor;
    localparam int NS    = 3;
    localparam int W     = 16;
    localparam int DEPTH = 8;
    localparam int PER   = 24;
    localparam int MAXL  = 12;
    localparam int NEV   = 60;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NS-1:0]     in_valid = '0;
    logic [NS-1:0]     in_last = '0;
    logic [NS*W-1:0]   in_data = '0;
    logic [PER-1:0]    out_valid, out_sop, out_eop, out_trunc;
    logic [PER*W-1:0]  out_data;

    int vectors = 0;
    int fails   = 0;
    int eop_seen = 0;
    bit ev_ready = 0;
    bit mon_on   = 0;

    logic [W-1:0] words [NS][MAXL];
    int           len [NS];
    logic [23:0]  exp_q [$];

    always #5 clk = ~clk;

    tmx_distributor #(.NUM_SRC(NS), .DATA_W(W), .BUF_DEPTH(DEPTH), .PERIOD(PER)) i_tmx_distributor (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last), .in_data(in_data),
        .out_valid(out_valid), .out_sop(out_sop), .out_eop(out_eop),
        .out_trunc(out_trunc), .out_data(out_data)
    );

    function automatic bit word_kept(int l, int i);
        return (l <= DEPTH) || (i < DEPTH - 1) || (i == l - 1);
    endfunction

    function automatic int dest_node(int ev);
        return ev % PER;
    endfunction

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Link monitor
    always @(negedge clk) begin
        if (mon_on) begin
            check($onehot0(out_valid), "R6 one link valid", 32'(out_valid), 32'h0);
            for (int n = 0; n < PER; n++) begin
                if (out_valid[n]) begin
                    logic [23:0] act, exp;
                    act = {5'(n), out_sop[n], out_eop[n], out_trunc[n], out_data[n*W +: W]};
                    check(ev_ready, "R2 word before all frames closed", 32'(act), 32'h0);
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R3 unexpected word", 32'(act), 32'h0);
                    end else begin
                        exp = exp_q.pop_front();
                        if (act[23:19] != exp[23:19])
                            check(1'b0, "R5 destination node", 32'(act[23:19]), 32'(exp[23:19]));
                        else if (act[15:0] != exp[15:0])
                            check(1'b0, "R3 word order/content", 32'(act[15:0]), 32'(exp[15:0]));
                        else if (act[18:17] != exp[18:17])
                            check(1'b0, "R4 sop/eop framing", 32'(act[18:17]), 32'(exp[18:17]));
                        else
                            check(act[16] == exp[16], "R8 truncation flag", 32'(act[16]), 32'(exp[16]));
                    end
                    if (out_eop[n]) begin
                        eop_seen++;
                        ev_ready = 0;
                    end
                end
            end
        end
    end

    function automatic bit all_sent(int sent[NS]);
        for (int s = 0; s < NS; s++) if (sent[s] < len[s]) return 0;
        return 1;
    endfunction

    task automatic run_event(int ev);
        int  sent [NS];
        bit  tr;
        tr = 0;
        for (int s = 0; s < NS; s++) begin
            sent[s] = 0;
            if (len[s] > DEPTH) tr = 1;
            for (int i = 0; i < MAXL; i++) words[s][i] = W'($urandom);
        end
        for (int s = 0; s < NS; s++)
            for (int i = 0; i < len[s]; i++)
                if (word_kept(len[s], i))
                    exp_q.push_back({5'(dest_node(ev)), (s == 0 && i == 0),
                                     (s == NS - 1 && i == len[s] - 1), tr, words[s][i]});
        while (!all_sent(sent)) begin
            @(negedge clk);
            for (int s = 0; s < NS; s++) begin
                if (sent[s] < len[s] && ($urandom % 4 != 0)) begin
                    in_valid[s] = 1'b1;
                    in_last[s]  = (sent[s] == len[s] - 1);
                    in_data[s*W +: W] = words[s][sent[s]];
                    sent[s]++;
                end else if (sent[s] >= len[s] && ($urandom % 2 == 1)) begin
                    // R7: junk after the source's last word
                    in_valid[s] = 1'b1;
                    in_last[s]  = 1'($urandom % 2);
                    in_data[s*W +: W] = 16'hBAD0 | 16'(s);
                end else begin
                    in_valid[s] = 1'b0;
                    in_last[s]  = 1'b0;
                end
            end
        end
        ev_ready = 1;
        repeat (2) begin
            @(negedge clk);
            in_valid = '1;
            in_last  = 3'($urandom);
            in_data  = {NS{16'hDEAD}};
        end
        @(negedge clk);
        in_valid = '0;
        in_last  = '0;
        wait (eop_seen == ev + 1);
        repeat (2) @(negedge clk);
        check(exp_q.size() == 0, "R3 R7 burst length", 32'(exp_q.size()), 32'h0);
    endtask

    task automatic run_all();
        repeat (5) @(negedge clk);
        check(out_valid == '0, "R1 reset idle links", 32'(out_valid), 32'h0);
        rst_n = 1'b1;
        mon_on = 1;
        repeat (3) @(negedge clk);
        check(out_valid == '0, "R1 idle after reset", 32'(out_valid), 32'h0);
        check($bits(out_valid) == 24, "R9 default period links", 32'($bits(out_valid)), 32'd24);
        for (int ev = 0; ev < NEV; ev++) begin
            case (ev)
                0:       for (int s = 0; s < NS; s++) len[s] = 1;
                1:       for (int s = 0; s < NS; s++) len[s] = DEPTH;
                2:       begin len[0] = DEPTH + 1; len[1] = 1; len[2] = 2; end
                3:       begin len[0] = 1; len[1] = 1; len[2] = 1; end
                4:       begin len[0] = 1; len[1] = MAXL; len[2] = DEPTH; end
                default: for (int s = 0; s < NS; s++) len[s] = 1 + int'($urandom % 11);
            endcase
            run_event(ev);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                check(1'b0, "R2 watchdog expired", 32'h0, 32'h1);
            end
        join_any
        disable fork;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule